// File: doc/BRIEF.md
# Integer Execute Unit with Decode and Register Storage

This block is the integer execute stage of a 32-bit load-store processor core. Each cycle it may accept one instruction word. It decodes the word and reads its two source operands from a 32-entry register file that it holds itself. It then computes an arithmetic, logic, shift or compare result and writes that result back into the register file. Immediate extension and shift-amount selection happen inside the block. A trapping add or subtract that overflows raises a flag and leaves its destination untouched. Memory access, branches, multiply and divide are decoded as unrecognised and have no effect.

The result, the destination index, the write strobe and the trap flag are registered and appear one cycle after the instruction is accepted. Write-back takes place on that same clock edge, so the very next instruction already reads the new value. Source fields are rs at bits 25:21 and rt at bits 20:16, and the opcode sits at bits 31:26. Register 0 is a constant zero source and a write sink.

Top module: `alu_exec_core`

## Requirements
- R1: While `rst` is high on a clock edge, the next cycle shows `out_valid`, `out_wr_en` and `out_ovf_trap` low, with `out_result` and `out_dest` zero.
- R2: An instruction presented with `in_valid` high shows its outputs, with `out_valid` high, exactly one cycle later, and its write-back is visible to an instruction in the following cycle. When `in_valid` is low, the next cycle has `out_valid`, `out_wr_en` and `out_ovf_trap` low and no register changes.
- R3: Opcode 0x00 selects a register-register operation by bits 5:0: 0x20 add, 0x21 add without trap, 0x22 subtract, 0x23 subtract without trap, 0x24 and, 0x25 or, 0x26 xor. Operands are rs and rt, and the destination is bits 15:11.
- R4: Immediate opcodes take the 16-bit immediate from bits 15:0 and write to the rt field (bits 20:16). 0x08 add, 0x09 add without trap, 0x0A and 0x0B compare, all with a sign-extended immediate. 0x0C and, 0x0D or, 0x0E xor, all with a zero-extended immediate.
- R5: Opcode 0x0F places the immediate in result bits 31:16 and clears bits 15:0. The rs field is ignored.
- R6: Shifts under opcode 0x00 act on rt. Function 0x00 is left logical, 0x02 right logical and 0x03 right arithmetic, each by bits 10:6. Function 0x04 is left and 0x06 is right logical, each by the low five bits of rs. Logical shifts fill with zeros and arithmetic shifts fill with the sign bit.
- R7: Compares produce exactly 1 or 0. Function 0x2A and opcode 0x0A compare as signed numbers. Function 0x2B and opcode 0x0B compare as unsigned numbers, with 0x0B using the sign-extended immediate.
- R8: Function 0x20, function 0x22 and opcode 0x08 raise `out_ovf_trap` on two's-complement overflow. `out_result` then carries the wrapped value, `out_wr_en` is low and the destination keeps its old value.
- R9: Function 0x21, function 0x23 and opcode 0x09 wrap modulo 2^32 and never raise `out_ovf_trap`.
- R10: Register 0 always reads as zero. A result aimed at register 0 shows `out_dest` 0 with `out_wr_en` low and is not stored. The all-zero word therefore changes nothing.
- R11: Any other opcode, or any other function code under opcode 0x00, gives `out_result` 0, `out_dest` 0, and `out_wr_en` and `out_ovf_trap` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| in_instr | input | 32 | Instruction word |
| out_valid | output | 1 | Outputs belong to the instruction accepted last cycle |
| out_result | output | 32 | Computed result |
| out_dest | output | 5 | Destination register index |
| out_wr_en | output | 1 | Result was written to the register file |
| out_ovf_trap | output | 1 | Trapping arithmetic overflowed |

## Verification
The checker watches, on every cycle, the relations that need no data values. It checks the one-cycle valid latency and that idle cycles stay quiet. It also checks that a trap never comes with a write, that no write goes to register 0, and that an immediate form reports rt as its destination. Finally it checks that compare results are a single bit, that the upper-immediate form has a clear low half, that the non-trapping forms never trap, and that unrecognised opcodes do nothing. Only the bench scenarios can show that the numbers are right. That covers extension choices, shift fills, signed against unsigned ordering, and overflow edges at the most positive and most negative values. It also covers that a trapped or idle instruction really left the register file unchanged, which the bench observes by reading the register back in a later instruction.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

  // opcode field values
  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ADDIU = 6'h09;
  localparam logic [5:0] OPC_SLTI  = 6'h0A;
  localparam logic [5:0] OPC_SLTIU = 6'h0B;
  localparam logic [5:0] OPC_ANDI  = 6'h0C;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_XORI  = 6'h0E;
  localparam logic [5:0] OPC_LUI   = 6'h0F;

  // function field values under OPC_REG
  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_SLLV = 6'h04;
  localparam logic [5:0] FN_SRLV = 6'h06;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    XOP_NONE,
    XOP_ADD,
    XOP_SUB,
    XOP_AND,
    XOP_OR,
    XOP_XOR,
    XOP_SLT,
    XOP_SLTU,
    XOP_SHL,
    XOP_SHR,
    XOP_SAR,
    XOP_UPPER
  } xop_e;

  typedef struct packed {
    xop_e op;
    logic use_imm;
    logic imm_zext;
    logic shift_var;
    logic trap_ovf;
  } exec_ctrl_t;

endpackage

// File: rtl/alu_exec_decode.sv
module alu_exec_decode
  import alu_exec_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [5:0]    opcode,
  input  logic [5:0]    funct,
  input  logic [AW-1:0] rt_field,
  input  logic [AW-1:0] rd_field,
  output exec_ctrl_t    ctrl,
  output logic          legal,
  output logic [AW-1:0] dest
);

  logic to_rt;

  always_comb begin
    ctrl  = '{op: XOP_NONE, use_imm: 1'b0, imm_zext: 1'b0,
              shift_var: 1'b0, trap_ovf: 1'b0};
    legal = 1'b1;
    to_rt = 1'b1;
    unique case (opcode)
      OPC_REG: begin
        to_rt = 1'b0;
        unique case (funct)
          FN_ADD:  begin ctrl.op = XOP_ADD; ctrl.trap_ovf = 1'b1; end
          FN_ADDU: ctrl.op = XOP_ADD;
          FN_SUB:  begin ctrl.op = XOP_SUB; ctrl.trap_ovf = 1'b1; end
          FN_SUBU: ctrl.op = XOP_SUB;
          FN_AND:  ctrl.op = XOP_AND;
          FN_OR:   ctrl.op = XOP_OR;
          FN_XOR:  ctrl.op = XOP_XOR;
          FN_SLT:  ctrl.op = XOP_SLT;
          FN_SLTU: ctrl.op = XOP_SLTU;
          FN_SLL:  ctrl.op = XOP_SHL;
          FN_SRL:  ctrl.op = XOP_SHR;
          FN_SRA:  ctrl.op = XOP_SAR;
          FN_SLLV: begin ctrl.op = XOP_SHL; ctrl.shift_var = 1'b1; end
          FN_SRLV: begin ctrl.op = XOP_SHR; ctrl.shift_var = 1'b1; end
          default: legal = 1'b0;
        endcase
      end
      OPC_ADDI:  begin ctrl.op = XOP_ADD;  ctrl.use_imm = 1'b1; ctrl.trap_ovf = 1'b1; end
      OPC_ADDIU: begin ctrl.op = XOP_ADD;  ctrl.use_imm = 1'b1; end
      OPC_SLTI:  begin ctrl.op = XOP_SLT;  ctrl.use_imm = 1'b1; end
      OPC_SLTIU: begin ctrl.op = XOP_SLTU; ctrl.use_imm = 1'b1; end
      OPC_ANDI:  begin ctrl.op = XOP_AND;  ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_ORI:   begin ctrl.op = XOP_OR;   ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_XORI:  begin ctrl.op = XOP_XOR;  ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      OPC_LUI:   begin ctrl.op = XOP_UPPER; ctrl.use_imm = 1'b1; ctrl.imm_zext = 1'b1; end
      default:   legal = 1'b0;
    endcase
    if (!legal) begin
      ctrl = '{op: XOP_NONE, use_imm: 1'b0, imm_zext: 1'b0,
               shift_var: 1'b0, trap_ovf: 1'b0};
    end
  end

  assign dest = !legal ? '0 : (to_rt ? rt_field : rd_field);

endmodule

// File: rtl/alu_exec_datapath.sv
module alu_exec_datapath
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMM_W = 16,
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  exec_ctrl_t         ctrl,
  input  logic [XLEN-1:0]    rs_val,
  input  logic [XLEN-1:0]    rt_val,
  input  logic [IMM_W-1:0]   imm,
  input  logic [SHAMT_W-1:0] shamt_fixed,
  output logic [XLEN-1:0]    result,
  output logic               ovf
);

  localparam int PAD_W = XLEN - IMM_W;

  logic [XLEN-1:0]    imm_ext;
  logic [XLEN-1:0]    opb;
  logic [XLEN-1:0]    addend;
  logic [XLEN-1:0]    sum;
  logic [SHAMT_W-1:0] shamt;
  logic               is_sub;
  logic               ovf_raw;

  always_comb begin
    imm_ext = ctrl.imm_zext ? {{PAD_W{1'b0}}, imm} : {{PAD_W{imm[IMM_W-1]}}, imm};
    opb     = ctrl.use_imm ? imm_ext : rt_val;
    is_sub  = (ctrl.op == XOP_SUB);
    addend  = is_sub ? ~opb : opb;
    sum     = rs_val + addend + {{(XLEN-1){1'b0}}, is_sub};
    ovf_raw = (rs_val[XLEN-1] == addend[XLEN-1]) && (sum[XLEN-1] != rs_val[XLEN-1]);
    shamt   = ctrl.shift_var ? rs_val[SHAMT_W-1:0] : shamt_fixed;

    unique case (ctrl.op)
      XOP_ADD, XOP_SUB: result = sum;
      XOP_AND:   result = rs_val & opb;
      XOP_OR:    result = rs_val | opb;
      XOP_XOR:   result = rs_val ^ opb;
      XOP_SLT:   result = {{(XLEN-1){1'b0}}, $signed(rs_val) < $signed(opb)};
      XOP_SLTU:  result = {{(XLEN-1){1'b0}}, rs_val < opb};
      XOP_SHL:   result = rt_val << shamt;
      XOP_SHR:   result = rt_val >> shamt;
      XOP_SAR:   result = $unsigned($signed(rt_val) >>> shamt);
      XOP_UPPER: result = {imm, {PAD_W{1'b0}}};
      default:   result = '0;
    endcase

    ovf = ctrl.trap_ovf && ovf_raw;
  end

endmodule

// File: rtl/alu_exec_regfile.sv
module alu_exec_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 2,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][XLEN-1:0]  rd_data,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [XLEN-1:0]           wr_data
);

  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr != '0)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (rd_addr[p] == '0) ? '0 : mem[rd_addr[p]];
  end

endmodule

// File: rtl/alu_exec_core.sv
module alu_exec_core
  import alu_exec_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int SHAMT_W = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic [AW-1:0]   out_dest,
  output logic            out_wr_en,
  output logic            out_ovf_trap
);

  localparam int RS_LSB = 21;
  localparam int RT_LSB = 16;
  localparam int RD_LSB = 11;
  localparam int SH_LSB = 6;

  exec_ctrl_t               ctrl;
  logic                     legal;
  logic [AW-1:0]            dest;
  logic [1:0][AW-1:0]       rd_addr;
  logic [1:0][XLEN-1:0]     rd_data;
  logic [XLEN-1:0]          result;
  logic                     ovf;
  logic                     commit;

  alu_exec_decode #(.AW(AW)) u_dec (
    .opcode   (in_instr[31:26]),
    .funct    (in_instr[5:0]),
    .rt_field (in_instr[RT_LSB +: AW]),
    .rd_field (in_instr[RD_LSB +: AW]),
    .ctrl     (ctrl),
    .legal    (legal),
    .dest     (dest)
  );

  assign rd_addr[0] = in_instr[RS_LSB +: AW];
  assign rd_addr[1] = in_instr[RT_LSB +: AW];

  alu_exec_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(2)) u_rf (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (commit),
    .wr_addr (dest),
    .wr_data (result)
  );

  alu_exec_datapath #(.XLEN(XLEN), .IMM_W(16)) u_dp (
    .ctrl        (ctrl),
    .rs_val      (rd_data[0]),
    .rt_val      (rd_data[1]),
    .imm         (in_instr[15:0]),
    .shamt_fixed (in_instr[SH_LSB +: SHAMT_W]),
    .result      (result),
    .ovf         (ovf)
  );

  assign commit = in_valid && legal && !ovf && (dest != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_dest     <= '0;
      out_wr_en    <= 1'b0;
      out_ovf_trap <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_result   <= result;
      out_dest     <= dest;
      out_wr_en    <= commit;
      out_ovf_trap <= in_valid && ovf;
    end
  end

endmodule

// File: rtl/alu_exec_core_chk.sv
module alu_exec_core_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [5:0]      opc,
  input logic [5:0]      fnc,
  input logic [AW-1:0]   rt_f,
  input logic            out_valid,
  input logic [XLEN-1:0] out_result,
  input logic [AW-1:0]   out_dest,
  input logic            out_wr_en,
  input logic            out_ovf_trap
);

  logic is_imm_op, is_cmp, is_nontrap, is_unknown_opc;

  assign is_imm_op      = (opc >= 6'h08) && (opc <= 6'h0F);
  assign is_cmp         = (opc == 6'h0A) || (opc == 6'h0B) ||
                          ((opc == 6'h00) && ((fnc == 6'h2A) || (fnc == 6'h2B)));
  assign is_nontrap     = (opc == 6'h09) ||
                          ((opc == 6'h00) && ((fnc == 6'h21) || (fnc == 6'h23)));
  assign is_unknown_opc = (opc != 6'h00) && !is_imm_op;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_wr_en && !out_ovf_trap)); // R1

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_wr_en && !out_ovf_trap)); // R2

  AST_IMM_DEST: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_imm_op) |=> (out_dest == $past(rt_f))); // R4

  AST_UPPER_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opc == 6'h0F)) |=> (out_result[15:0] == 16'h0)); // R5

  AST_CMP_SINGLE_BIT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> (out_result[XLEN-1:1] == '0)); // R7

  AST_NO_WRITE_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    out_ovf_trap |-> !out_wr_en); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_nontrap) |=> !out_ovf_trap); // R9

  AST_ZERO_SINK: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> (out_dest != '0)); // R10

  AST_UNKNOWN_INERT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_unknown_opc) |=> (!out_wr_en && !out_ovf_trap && out_result == '0)); // R11

endmodule

bind alu_exec_core alu_exec_core_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .opc          (in_instr[31:26]),
  .fnc          (in_instr[5:0]),
  .rt_f         (in_instr[20:16]),
  .out_valid    (out_valid),
  .out_result   (out_result),
  .out_dest     (out_dest),
  .out_wr_en    (out_wr_en),
  .out_ovf_trap (out_ovf_trap)
);

// File: tb/alu_exec_core_bench.sv
`timescale 1ns/1ps
module alu_exec_core_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic [4:0]  out_dest;
  logic        out_wr_en;
  logic        out_ovf_trap;

  always #2.5 clk = ~clk;

  alu_exec_core u_alu_exec_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(out_valid), .out_result(out_result), .out_dest(out_dest),
    .out_wr_en(out_wr_en), .out_ovf_trap(out_ovf_trap)
  );

  typedef struct {
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we;
    logic        ovf;
    string       tag;
  } exp_t;

  exp_t        expq[$];
  logic [31:0] m [32];
  int          nchk = 0;
  int          nbad = 0;
  bit          live = 0;
  bit          done = 0;

  function automatic logic [31:0] rr(input logic [5:0] fn, input logic [4:0] s,
                                     input logic [4:0] t, input logic [4:0] d,
                                     input logic [4:0] h);
    return {6'h00, s, t, d, h, fn};
  endfunction

  function automatic logic [31:0] ri(input logic [5:0] op, input logic [4:0] s,
                                     input logic [4:0] t, input logic [15:0] imm);
    return {op, s, t, imm};
  endfunction

  // Reference from the requirement text
  function automatic exp_t model(input logic [31:0] ins);
    exp_t        e;
    logic [5:0]  op = ins[31:26];
    logic [5:0]  fn = ins[5:0];
    logic [31:0] a  = m[ins[25:21]];
    logic [31:0] b  = m[ins[20:16]];
    logic [31:0] se = {{16{ins[15]}}, ins[15:0]};
    logic [31:0] ze = {16'h0, ins[15:0]};
    logic [4:0]  h  = ins[10:6];
    bit          ok = 1;
    e.res = '0; e.dst = '0; e.we = 0; e.ovf = 0; e.tag = "";
    if (op == 6'h00) begin
      e.dst = ins[15:11];
      case (fn)
        6'h20: begin e.res = a + b; e.ovf = (a[31] == b[31]) && (e.res[31] != a[31]); end
        6'h21: e.res = a + b;
        6'h22: begin e.res = a - b; e.ovf = (a[31] != b[31]) && (e.res[31] != a[31]); end
        6'h23: e.res = a - b;
        6'h24: e.res = a & b;
        6'h25: e.res = a | b;
        6'h26: e.res = a ^ b;
        6'h2A: e.res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h2B: e.res = (a < b) ? 32'd1 : 32'd0;
        6'h00: e.res = b << h;
        6'h02: e.res = b >> h;
        6'h03: e.res = $unsigned($signed(b) >>> h);
        6'h04: e.res = b << a[4:0];
        6'h06: e.res = b >> a[4:0];
        default: ok = 0;
      endcase
    end else begin
      e.dst = ins[20:16];
      case (op)
        6'h08: begin e.res = a + se; e.ovf = (a[31] == se[31]) && (e.res[31] != a[31]); end
        6'h09: e.res = a + se;
        6'h0A: e.res = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
        6'h0B: e.res = (a < se) ? 32'd1 : 32'd0;
        6'h0C: e.res = a & ze;
        6'h0D: e.res = a | ze;
        6'h0E: e.res = a ^ ze;
        6'h0F: e.res = {ins[15:0], 16'h0};
        default: ok = 0;
      endcase
    end
    if (!ok) begin e.res = '0; e.dst = '0; e.ovf = 0; end
    e.we = ok && !e.ovf && (e.dst != 0);
    return e;
  endfunction

  task automatic issue(input logic [31:0] ins, input string tag);
    exp_t e;
    e = model(ins);
    e.tag = tag;
    if (e.we) m[e.dst] = e.res;
    expq.push_back(e);
    @(negedge clk);
    in_valid = 1'b1;
    in_instr = ins;
  endtask

  task automatic idle(input logic [31:0] ins);
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = ins;
  endtask

  // Monitor: pops the scoreboard when results arrive
  always @(negedge clk) begin
    if (live && !rst) begin
      if (out_valid) begin
        nchk++;
        if (expq.size() == 0) begin
          nbad++;
          $display("FAIL R2: unexpected result got res=%h dst=%0d, expected none", out_result, out_dest);
        end else begin
          exp_t e;
          e = expq.pop_front();
          if (out_result !== e.res || out_dest !== e.dst ||
              out_wr_en !== e.we || out_ovf_trap !== e.ovf) begin
            nbad++;
            $display("FAIL %s: got res=%h dst=%0d we=%b ovf=%b expected res=%h dst=%0d we=%b ovf=%b",
                     e.tag, out_result, out_dest, out_wr_en, out_ovf_trap,
                     e.res, e.dst, e.we, e.ovf);
          end
        end
      end else begin
        nchk++;
        if (out_wr_en !== 1'b0 || out_ovf_trap !== 1'b0) begin
          nbad++;
          $display("FAIL R2: idle cycle got we=%b ovf=%b expected we=0 ovf=0", out_wr_en, out_ovf_trap);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    nchk++;
    if (out_valid !== 0 || out_wr_en !== 0 || out_ovf_trap !== 0 || out_result !== 0 || out_dest !== 0) begin
      nbad++;
      $display("FAIL R1: got v=%b we=%b ovf=%b res=%h dst=%0d expected all zero",
               out_valid, out_wr_en, out_ovf_trap, out_result, out_dest);
    end
    rst = 1'b0;
    live = 1;

    // operand setup through normal instructions (R4 R5 R2)
    issue(ri(6'h0F, 5'd0, 5'd1, 16'h7FFF), "R5 upper");
    issue(ri(6'h0D, 5'd1, 5'd1, 16'hFFFF), "R4 or-imm back-to-back");
    issue(ri(6'h0D, 5'd0, 5'd2, 16'h0001), "R4 or-imm");
    issue(ri(6'h0F, 5'd7, 5'd3, 16'h8000), "R5 upper ignores rs");
    issue(ri(6'h0F, 5'd0, 5'd4, 16'hFFFF), "R5 upper");
    issue(ri(6'h0D, 5'd4, 5'd4, 16'hFFF0), "R4 or-imm");
    issue(ri(6'h0D, 5'd0, 5'd5, 16'h0024), "R4 or-imm");
    issue(ri(6'h0F, 5'd0, 5'd6, 16'h1234), "R5 upper");
    issue(ri(6'h0D, 5'd6, 5'd6, 16'h5678), "R4 or-imm");
    issue(ri(6'h0D, 5'd0, 5'd9, 16'h0055), "R4 or-imm");

    // register-register arithmetic and logic
    issue(rr(6'h20, 5'd6, 5'd2, 5'd7, 5'd0), "R3 add");
    issue(rr(6'h21, 5'd1, 5'd2, 5'd8, 5'd0), "R9 add no trap wraps");
    issue(rr(6'h20, 5'd1, 5'd2, 5'd9, 5'd0), "R8 add overflow");
    issue(rr(6'h25, 5'd9, 5'd0, 5'd10, 5'd0), "R8 destination kept");
    issue(rr(6'h22, 5'd3, 5'd2, 5'd11, 5'd0), "R8 subtract overflow");
    issue(rr(6'h23, 5'd3, 5'd2, 5'd12, 5'd0), "R9 subtract no trap");
    issue(rr(6'h22, 5'd6, 5'd2, 5'd13, 5'd0), "R3 subtract");
    issue(rr(6'h24, 5'd6, 5'd4, 5'd14, 5'd0), "R3 and");
    issue(rr(6'h25, 5'd6, 5'd4, 5'd15, 5'd0), "R3 or");
    issue(rr(6'h26, 5'd6, 5'd4, 5'd16, 5'd0), "R3 xor");

    // compares
    issue(rr(6'h2A, 5'd4, 5'd2, 5'd17, 5'd0), "R7 signed less");
    issue(rr(6'h2B, 5'd4, 5'd2, 5'd18, 5'd0), "R7 unsigned less");
    issue(ri(6'h0A, 5'd4, 5'd19, 16'hFFF8), "R7 signed imm");
    issue(ri(6'h0B, 5'd2, 5'd20, 16'hFFFF), "R7 unsigned imm sign-extended");
    issue(ri(6'h0B, 5'd4, 5'd21, 16'h0001), "R7 unsigned imm false");

    // immediates
    issue(ri(6'h08, 5'd2, 5'd22, 16'hFFFF), "R4 add-imm sign-extended");
    issue(ri(6'h08, 5'd1, 5'd23, 16'h0001), "R8 add-imm overflow");
    issue(ri(6'h09, 5'd1, 5'd24, 16'hFFFF), "R9 add-imm no trap sign-extended");
    issue(ri(6'h09, 5'd1, 5'd25, 16'h0001), "R9 add-imm wraps");
    issue(ri(6'h0C, 5'd4, 5'd26, 16'hFF0F), "R4 and-imm zero-extended");
    issue(ri(6'h0E, 5'd4, 5'd27, 16'hFFFF), "R4 xor-imm zero-extended");

    // shifts
    issue(rr(6'h00, 5'd0, 5'd6, 5'd28, 5'd4), "R6 shift left fixed");
    issue(rr(6'h02, 5'd0, 5'd3, 5'd29, 5'd31), "R6 shift right logical fixed");
    issue(rr(6'h03, 5'd0, 5'd3, 5'd30, 5'd4), "R6 arithmetic fill sign");
    issue(rr(6'h03, 5'd0, 5'd6, 5'd31, 5'd8), "R6 arithmetic fill zero");
    issue(rr(6'h04, 5'd5, 5'd6, 5'd28, 5'd0), "R6 shift left variable low bits");
    issue(rr(6'h06, 5'd5, 5'd4, 5'd29, 5'd0), "R6 shift right variable");

    // register zero
    issue(rr(6'h21, 5'd6, 5'd6, 5'd0, 5'd0), "R10 write to zero");
    issue(rr(6'h25, 5'd0, 5'd0, 5'd10, 5'd0), "R10 zero reads zero");
    issue(32'h0000_0000, "R10 all-zero word");
    issue(rr(6'h21, 5'd0, 5'd6, 5'd11, 5'd0), "R10 zero as source");

    // unrecognised
    issue(ri(6'h23, 5'd6, 5'd12, 16'h0004), "R11 memory opcode");
    issue(rr(6'h18, 5'd6, 5'd2, 5'd12, 5'd0), "R11 multiply function");
    issue(rr(6'h07, 5'd5, 5'd6, 5'd12, 5'd0), "R11 unknown shift function");
    issue(rr(6'h25, 5'd12, 5'd0, 5'd13, 5'd0), "R11 destination kept");

    // idle with a writing word present, then read back
    idle(ri(6'h0D, 5'd0, 5'd6, 16'h00FF));
    idle(ri(6'h0D, 5'd0, 5'd6, 16'h00FF));
    issue(rr(6'h25, 5'd6, 5'd0, 5'd14, 5'd0), "R2 idle left register");

    repeat (4) idle(32'h0);
    nchk++;
    if (expq.size() != 0) begin
      nbad++;
      $display("FAIL R2: got %0d pending results expected 0", expq.size());
    end
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

endmodule